// File: doc/BRIEF.md
# Control Endpoint Setup Capture Unit

This block sits between a USB device packet engine and the software that services control endpoints. The engine presents a setup token, naming the endpoint, and then the eight payload bytes of the setup packet, one byte per valid cycle. The unit gathers the bytes in a staging register. It then writes the complete packet, in a single cycle, into a per-endpoint setup buffer that software reads through a small register port.

A new setup packet can arrive while software is still copying the previous one. Two protection schemes guard against a torn copy, and a control bit selects between them. In lockout mode, a packet aimed at an endpoint whose setup-status bit is still set is dropped. In release mode, every packet is accepted, and a software-owned tripwire bit is knocked down by the hardware whenever a packet lands. Software sets the tripwire, copies the buffer, and re-reads the tripwire. If the bit has fallen, software copies the buffer again.

The unit also tracks endpoint priming. A prime request raises a prime bit. A completion pulse from the engine then either reports success by raising a ready bit, or the prime fails. A prime fails when a setup packet lands on the same endpoint during the prime: the prime bit drops and the ready bit stays low.

Top module: `setup_capture_unit`

## Requirements
- R1: While reset is asserted, and at its release, every register reads 0: control (address 0), setup status (1), prime (2), ready (3) and all setup buffers (4 and up). A control value of 0 means lockout mode with the tripwire low.
- R2: The eight bytes that follow a token are stored for the token's endpoint e. Byte i sits in bits [8i+7:8i] of address 4+2e for i<4, and in bits [8(i-4)+7:8(i-4)] of address 5+2e for i>=4. The buffer changes only at the clock edge that samples the eighth byte, and all eight bytes change together. Valid bytes after the eighth, with no new token, are ignored.
- R3: The edge that stores an accepted packet for endpoint e sets bit e of the setup-status register (address 1). Writing 1 to that bit at address 1 clears it.
- R4: If a packet is accepted for endpoint e in the same cycle that software writes 1 to status bit e, the bit stays set.
- R5: Control bit 0 selects the protection mode. When it is 0 (lockout), a packet whose eighth byte arrives while the status bit of its endpoint is 1 is dropped: the buffer, the tripwire and the prime state stay unchanged. Packets for other endpoints are still accepted.
- R6: When control bit 0 is 1 (release), a packet is accepted even if the status bit of its endpoint is set.
- R7: Control bit 1 is the tripwire. Writing the control register loads both bits from write data bits 1:0. Every accepted packet clears the tripwire, and that clear wins over a control write of 1 in the same cycle.
- R8: Writing 1 to bit e of address 2 sets prime bit e and clears ready bit e (address 3).
- R9: A completion pulse on prime_done[e] while prime bit e is set clears the prime bit and sets ready bit e; both changes are readable in the next cycle. A pulse while the prime bit is clear has no effect.
- R10: A packet accepted for endpoint e while prime bit e is set clears that prime bit and leaves ready bit e at 0, even if a completion pulse for e arrives in the same cycle. Primes on other endpoints are not affected.
- R11: A token restarts the byte count and discards any partially gathered packet; the bytes that follow it form a fresh packet for the endpoint the new token names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_tok | input | 1 | Setup token pulse; starts a new packet |
| rx_tok_ep | input | EP_W | Endpoint named by the token |
| rx_valid | input | 1 | A payload byte is present on rx_data |
| rx_data | input | BYTE_W | Payload byte |
| prime_done | input | NUM_EP | Per-endpoint prime completion pulse from the engine |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both read and write |
| reg_wdata | input | WR_W | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
A wrong internal state shows up at reg_rdata in the first cycle after the clock edge that produced it. The bench rotates reg_addr through every register, and a behavioural model compares the read data on every clock. A staging fault, such as a wrong byte slot or an early write, shows up as a buffer word that changes before the eighth byte or holds a misplaced byte. A wrong lockout decision or a wrong priority choice shows up as a status bit, tripwire, prime bit or ready bit that differs from the model in the cycle right after the event.

// File: rtl/setup_cap_pkg.sv
package setup_cap_pkg;
   localparam int REG_AW    = 4;
   localparam int REG_DW    = 32;
   localparam int PKT_BYTES = 8;

   localparam logic [REG_AW-1:0] ADR_CTRL  = 4'd0;
   localparam logic [REG_AW-1:0] ADR_SSTAT = 4'd1;
   localparam logic [REG_AW-1:0] ADR_PRIME = 4'd2;
   localparam logic [REG_AW-1:0] ADR_READY = 4'd3;
   localparam logic [REG_AW-1:0] ADR_BUF0  = 4'd4;

   typedef struct packed {
      logic tripwire;
      logic release_lock;
   } ctrl_t;
endpackage

// File: rtl/setup_rx_assembler.sv
module setup_rx_assembler #(
   parameter int EP_W      = 1,
   parameter int BYTE_W    = 8,
   parameter int PKT_BYTES = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tok,
   input  logic [EP_W-1:0]             tok_ep,
   input  logic                        valid,
   input  logic [BYTE_W-1:0]           data,
   output logic                        commit,
   output logic [EP_W-1:0]             commit_ep,
   output logic [PKT_BYTES*BYTE_W-1:0] commit_pkt
);
   localparam int LAST  = PKT_BYTES - 1;
   localparam int CNT_W = (PKT_BYTES > 2) ? $clog2(PKT_BYTES) : 1;

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic [EP_W-1:0]  ep_q;
   logic             take;

   assign take      = valid && armed_q && !tok;
   assign commit    = take && (cnt_q == CNT_W'(LAST));
   assign commit_ep = ep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         ep_q    <= '0;
      end else if (tok) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
         ep_q    <= tok_ep;
      end else if (take) begin
         if (cnt_q == CNT_W'(LAST)) armed_q <= 1'b0;
         else                        cnt_q   <= cnt_q + 1'b1;
      end
   end

   for (genvar i = 0; i < LAST; i++) begin : g_stage
      logic [BYTE_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           byte_q <= '0;
         else if (take && cnt_q == CNT_W'(i))  byte_q <= data;
      end
      assign commit_pkt[i*BYTE_W +: BYTE_W] = byte_q;
   end
   assign commit_pkt[LAST*BYTE_W +: BYTE_W] = data;
endmodule

// File: rtl/setup_buf_bank.sv
module setup_buf_bank #(
   parameter int NUM_EP = 2,
   parameter int PKT_W  = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_EP-1:0]       wr_oh,
   input  logic [PKT_W-1:0]        pkt,
   output logic [NUM_EP*PKT_W-1:0] buf_flat
);
   for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      logic [PKT_W-1:0] pkt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pkt_q <= '0;
         else if (wr_oh[e]) pkt_q <= pkt;
      end
      assign buf_flat[e*PKT_W +: PKT_W] = pkt_q;
   end
endmodule

// File: rtl/prime_tracker.sv
module prime_tracker #(
   parameter int NUM_EP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EP-1:0] req,
   input  logic [NUM_EP-1:0] done,
   input  logic [NUM_EP-1:0] fail,
   output logic [NUM_EP-1:0] prime_q,
   output logic [NUM_EP-1:0] ready_q
);
   for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      logic p_q, r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= 1'b0;
            r_q <= 1'b0;
         end else if (p_q && fail[e]) begin
            p_q <= 1'b0;
         end else if (p_q && done[e]) begin
            p_q <= 1'b0;
            r_q <= 1'b1;
         end else if (req[e]) begin
            p_q <= 1'b1;
            r_q <= 1'b0;
         end
      end
      assign prime_q[e] = p_q;
      assign ready_q[e] = r_q;
   end
endmodule

// File: rtl/setup_capture_unit.sv
module setup_capture_unit
   import setup_cap_pkg::*;
#(
   parameter int NUM_EP = 2,
   parameter int BYTE_W = 8,
   localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
   localparam int WR_W  = (NUM_EP > 2) ? NUM_EP : 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_tok,
   input  logic [EP_W-1:0]    rx_tok_ep,
   input  logic               rx_valid,
   input  logic [BYTE_W-1:0]  rx_data,
   input  logic [NUM_EP-1:0]  prime_done,
   input  logic               reg_wr,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [WR_W-1:0]    reg_wdata,
   output logic [REG_DW-1:0]  reg_rdata
);
   localparam int PKT_W  = PKT_BYTES * BYTE_W;
   localparam int HALF_W = PKT_W / 2;

   if (NUM_EP < 1 || NUM_EP > 4) begin : g_bad_ep
      $error("setup_capture_unit: NUM_EP must lie in 1..4");
   end
   if (BYTE_W * (PKT_BYTES / 2) != REG_DW) begin : g_bad_bw
      $error("setup_capture_unit: half a packet must fill one register word");
   end

   logic                     commit;
   logic [EP_W-1:0]          commit_ep;
   logic [PKT_W-1:0]         commit_pkt;
   logic [NUM_EP-1:0]        ep_oh;
   logic [NUM_EP-1:0]        accept_oh;
   logic                     locked;
   logic                     accept;
   logic [NUM_EP-1:0]        sstat_q;
   logic [NUM_EP-1:0]        prime_q;
   logic [NUM_EP-1:0]        ready_q;
   logic [NUM_EP*PKT_W-1:0]  buf_flat;
   ctrl_t                    ctrl_q;
   logic                     trip_q;
   logic [NUM_EP-1:0]        w1c;
   logic [NUM_EP-1:0]        prime_req;

   setup_rx_assembler #(.EP_W(EP_W), .BYTE_W(BYTE_W), .PKT_BYTES(PKT_BYTES)) u_asm (
      .clk(clk), .rst_n(rst_n), .tok(rx_tok), .tok_ep(rx_tok_ep),
      .valid(rx_valid), .data(rx_data),
      .commit(commit), .commit_ep(commit_ep), .commit_pkt(commit_pkt)
   );

   for (genvar e = 0; e < NUM_EP; e++) begin : g_dec
      assign ep_oh[e] = (commit_ep == EP_W'(e));
   end

   assign locked    = !ctrl_q.release_lock && |(sstat_q & ep_oh);
   assign accept    = commit && |ep_oh && !locked;
   assign accept_oh = accept ? ep_oh : '0;
   assign trip_q    = ctrl_q.tripwire;

   setup_buf_bank #(.NUM_EP(NUM_EP), .PKT_W(PKT_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_oh(accept_oh), .pkt(commit_pkt), .buf_flat(buf_flat)
   );

   assign w1c       = (reg_wr && reg_addr == ADR_SSTAT) ? reg_wdata[NUM_EP-1:0] : '0;
   assign prime_req = (reg_wr && reg_addr == ADR_PRIME) ? reg_wdata[NUM_EP-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sstat_q <= '0;
      else        sstat_q <= (sstat_q & ~w1c) | accept_oh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (reg_wr && reg_addr == ADR_CTRL) ctrl_q.release_lock <= reg_wdata[0];
         if (accept)                               ctrl_q.tripwire <= 1'b0;
         else if (reg_wr && reg_addr == ADR_CTRL)  ctrl_q.tripwire <= reg_wdata[1];
      end
   end

   prime_tracker #(.NUM_EP(NUM_EP)) u_prime (
      .clk(clk), .rst_n(rst_n), .req(prime_req), .done(prime_done),
      .fail(accept_oh), .prime_q(prime_q), .ready_q(ready_q)
   );

   always_comb begin
      int idx;
      reg_rdata = '0;
      idx = (int'(reg_addr) - int'(ADR_BUF0)) / 2;
      case (reg_addr)
         ADR_CTRL:  reg_rdata = REG_DW'({trip_q, ctrl_q.release_lock});
         ADR_SSTAT: reg_rdata = REG_DW'(sstat_q);
         ADR_PRIME: reg_rdata = REG_DW'(prime_q);
         ADR_READY: reg_rdata = REG_DW'(ready_q);
         default: begin
            if (reg_addr >= ADR_BUF0 && idx < NUM_EP)
               reg_rdata = buf_flat[idx*PKT_W + (reg_addr[0] ? HALF_W : 0) +: HALF_W];
         end
      endcase
   end
endmodule

// File: rtl/setup_capture_checker.sv
module setup_capture_checker #(
   parameter int NUM_EP = 2,
   parameter int PKT_W  = 64
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    commit,
   input logic                    locked,
   input logic                    accept,
   input logic [NUM_EP-1:0]       ep_oh,
   input logic [NUM_EP-1:0]       sstat_q,
   input logic [NUM_EP-1:0]       prime_q,
   input logic [NUM_EP-1:0]       ready_q,
   input logic                    trip_q,
   input logic [NUM_EP*PKT_W-1:0] buf_flat
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (sstat_q == '0 && prime_q == '0 && ready_q == '0 && !trip_q));

   assert_buf_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(buf_flat));

   assert_stat_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> |(sstat_q & $past(ep_oh)));

   assert_lockout_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && locked) |=> $stable(buf_flat) && $stable(trip_q) && $stable(prime_q));

   assert_trip_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !trip_q);

   assert_prime_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && |(prime_q & ep_oh)) |=>
         !(|(prime_q & $past(ep_oh))) && !(|(ready_q & $past(ep_oh))));
endmodule

bind setup_capture_unit setup_capture_checker #(.NUM_EP(NUM_EP), .PKT_W(PKT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .commit(commit), .locked(locked), .accept(accept),
   .ep_oh(ep_oh), .sstat_q(sstat_q), .prime_q(prime_q), .ready_q(ready_q),
   .trip_q(trip_q), .buf_flat(buf_flat)
);

// File: tb/setup_capture_unit_bench.sv
`timescale 1ns/1ps
module setup_capture_unit_bench;
   localparam int NEP = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_tok = 1'b0;
   logic [0:0]  rx_tok_ep = '0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic [1:0]  prime_done = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [1:0]  reg_wdata = '0;
   logic [31:0] reg_rdata;

   int checks = 0;
   int fails  = 0;
   int rot    = 0;

   setup_capture_unit #(.NUM_EP(NEP), .BYTE_W(8)) u_setup_capture_unit (
      .clk(clk), .rst_n(rst_n), .rx_tok(rx_tok), .rx_tok_ep(rx_tok_ep),
      .rx_valid(rx_valid), .rx_data(rx_data), .prime_done(prime_done),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   always #5 clk = ~clk;

   // behavioural reference model
   bit        m_rel = 0, m_trip = 0, m_armed = 0;
   bit [1:0]  m_stat = 0, m_prime = 0, m_ready = 0;
   logic [7:0] m_buf [NEP][8];
   logic [7:0] m_stage [8];
   int        m_cnt = 0, m_ep = 0;

   initial begin
      for (int e = 0; e < NEP; e++) for (int b = 0; b < 8; b++) m_buf[e][b] = 8'h00;
      for (int b = 0; b < 8; b++) m_stage[b] = 8'h00;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rel = 0; m_trip = 0; m_armed = 0; m_stat = 0; m_prime = 0; m_ready = 0;
         m_cnt = 0; m_ep = 0;
         for (int e = 0; e < NEP; e++) for (int b = 0; b < 8; b++) m_buf[e][b] = 8'h00;
      end else begin
         bit done8, acc;
         bit [1:0] w1c;
         done8 = rx_valid && m_armed && !rx_tok && m_cnt == 7;
         acc   = done8 && (m_rel || !m_stat[m_ep]);
         w1c   = (reg_wr && reg_addr == 4'd1) ? reg_wdata : 2'b00;
         if (acc) begin
            for (int b = 0; b < 7; b++) m_buf[m_ep][b] = m_stage[b];
            m_buf[m_ep][7] = rx_data;
         end
         for (int e = 0; e < NEP; e++) begin
            bit req;
            req = reg_wr && reg_addr == 4'd2 && reg_wdata[e];
            if (m_prime[e] && acc && m_ep == e) m_prime[e] = 0;
            else if (m_prime[e] && prime_done[e]) begin m_prime[e] = 0; m_ready[e] = 1; end
            else if (req) begin m_prime[e] = 1; m_ready[e] = 0; end
         end
         m_stat = (m_stat & ~w1c) | (acc ? (2'b01 << m_ep) : 2'b00);
         if (acc) m_trip = 0;
         else if (reg_wr && reg_addr == 4'd0) m_trip = reg_wdata[1];
         if (reg_wr && reg_addr == 4'd0) m_rel = reg_wdata[0];
         if (rx_tok) begin
            m_armed = 1; m_cnt = 0; m_ep = int'(rx_tok_ep);
         end else if (rx_valid && m_armed) begin
            m_stage[m_cnt] = rx_data;
            if (m_cnt == 7) m_armed = 0; else m_cnt++;
         end
      end
   end

   function automatic logic [31:0] exp_rd(input logic [3:0] a);
      int idx, hb;
      case (a)
         4'd0: return {30'd0, m_trip, m_rel};
         4'd1: return {30'd0, m_stat};
         4'd2: return {30'd0, m_prime};
         4'd3: return {30'd0, m_ready};
         default: begin
            idx = (int'(a) - 4) / 2;
            hb  = int'(a[0]) * 4;
            if (idx < NEP)
               return {m_buf[idx][hb+3], m_buf[idx][hb+2], m_buf[idx][hb+1], m_buf[idx][hb]};
            return 32'd0;
         end
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] a);
      if (!rst_n) return "R1";
      case (a)
         4'd0: return "R7";
         4'd1: return "R3";
         4'd2, 4'd3: return "R9";
         default: return "R2";
      endcase
   endfunction

   // per-clock comparison against the model
   always @(negedge clk) begin
      logic [31:0] e;
      e = exp_rd(reg_addr);
      checks++;
      if (reg_rdata !== e) begin
         fails++;
         $display("FAIL %s model compare addr=%0d actual=%h expected=%h",
                  tag_of(reg_addr), reg_addr, reg_rdata, e);
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic peek(input string tag, input logic [3:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      rx_tok = 0; rx_valid = 0; reg_wr = 0; prime_done = '0;
      reg_addr = 4'(rot);
      rot = (rot + 1) % 8;
   endtask

   task automatic wr(input logic [3:0] a, input logic [1:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      step();
   endtask

   task automatic send_partial(input int ep, input logic [7:0] base, input int n);
      rx_tok = 1; rx_tok_ep = 1'(ep);
      step();
      for (int i = 0; i < n; i++) begin
         rx_valid = 1; rx_data = base + 8'(i);
         step();
      end
   endtask

   task automatic send_setup(input int ep, input logic [7:0] base);
      send_partial(ep, base, 8);
   endtask

   function automatic logic [31:0] wrd(input logic [7:0] base, input int hi);
      logic [7:0] b0;
      b0 = base + 8'(hi * 4);
      return {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0};
   endfunction

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      for (int a = 0; a < 8; a++) peek("R1", 4'(a), 32'd0);
      rst_n = 1;
      step();
      for (int a = 0; a < 8; a++) peek("R1", 4'(a), 32'd0);

      // release mode, basic capture
      wr(4'd0, 2'b01);
      send_setup(0, 8'h10);
      peek("R2", 4'd4, wrd(8'h10, 0));
      peek("R2", 4'd5, wrd(8'h10, 1));
      peek("R3", 4'd1, 32'd1);

      // buffer holds until eighth byte
      send_partial(0, 8'h20, 7);
      peek("R2", 4'd4, wrd(8'h10, 0));
      rx_valid = 1; rx_data = 8'h27; step();
      peek("R2", 4'd4, wrd(8'h20, 0));
      peek("R2", 4'd5, wrd(8'h20, 1));

      // stray bytes ignored
      rx_valid = 1; rx_data = 8'hAA; step();
      rx_valid = 1; rx_data = 8'hAB; step();
      peek("R2", 4'd4, wrd(8'h20, 0));
      peek("R2", 4'd5, wrd(8'h20, 1));

      // write-1-to-clear
      wr(4'd1, 2'b01);
      peek("R3", 4'd1, 32'd0);

      // set beats clear
      send_partial(0, 8'h30, 7);
      rx_valid = 1; rx_data = 8'h37; reg_wr = 1; reg_addr = 4'd1; reg_wdata = 2'b01;
      step();
      peek("R4", 4'd1, 32'd1);
      peek("R2", 4'd4, wrd(8'h30, 0));

      // lockout mode with tripwire set
      wr(4'd0, 2'b10);
      peek("R7", 4'd0, 32'd2);
      send_setup(0, 8'h40);
      peek("R5", 4'd4, wrd(8'h30, 0));
      peek("R5", 4'd0, 32'd2);
      send_setup(1, 8'h50);
      peek("R5", 4'd6, wrd(8'h50, 0));
      peek("R7", 4'd0, 32'd0);
      peek("R3", 4'd1, 32'd3);

      // release mode accepts despite status
      wr(4'd0, 2'b01);
      send_setup(0, 8'h60);
      peek("R6", 4'd4, wrd(8'h60, 0));
      peek("R6", 4'd5, wrd(8'h60, 1));

      // tripwire write and priority
      wr(4'd0, 2'b11);
      peek("R7", 4'd0, 32'd3);
      wr(4'd0, 2'b01);
      peek("R7", 4'd0, 32'd1);
      send_partial(1, 8'h70, 7);
      rx_valid = 1; rx_data = 8'h77; reg_wr = 1; reg_addr = 4'd0; reg_wdata = 2'b11;
      step();
      peek("R7", 4'd0, 32'd1);
      peek("R2", 4'd7, wrd(8'h70, 1));

      // priming
      wr(4'd2, 2'b10);
      peek("R8", 4'd2, 32'd2);
      peek("R8", 4'd3, 32'd0);
      prime_done = 2'b10; step();
      peek("R9", 4'd2, 32'd0);
      peek("R9", 4'd3, 32'd2);
      prime_done = 2'b01; step();
      peek("R9", 4'd3, 32'd2);
      wr(4'd2, 2'b10);
      peek("R8", 4'd3, 32'd0);
      peek("R8", 4'd2, 32'd2);
      send_setup(0, 8'h80);
      peek("R10", 4'd2, 32'd2);
      send_setup(1, 8'h90);
      peek("R10", 4'd2, 32'd0);
      peek("R10", 4'd3, 32'd0);

      // failure beats completion in the same cycle
      wr(4'd2, 2'b01);
      send_partial(0, 8'hA0, 7);
      rx_valid = 1; rx_data = 8'hA7; prime_done = 2'b01;
      step();
      peek("R10", 4'd2, 32'd0);
      peek("R10", 4'd3, 32'd0);

      // restart on a new token
      send_partial(0, 8'hB0, 4);
      send_setup(1, 8'hC0);
      peek("R11", 4'd6, wrd(8'hC0, 0));
      peek("R11", 4'd7, wrd(8'hC0, 1));
      peek("R11", 4'd4, wrd(8'hA0, 0));

      repeat (20) step();
      finish_run();
   end
endmodule